// File: doc/BRIEF.md
# Single-Bus Register Datapath with Staged ALU

This block is the register half of a small processor: a program counter, a memory address register, a memory buffer register, an instruction register, an accumulator and two ALU staging registers (Y and Z) share one internal bus. Each cycle an outside sequencer asserts a set of strobes. Each strobe either lets one register drive the bus or lets one register capture the bus. The ALU is purely combinational. Its first operand comes from Y and its second from the bus, and its result can only be captured into Z. Z must then drive the bus in a later cycle before the value reaches any other register. An addition therefore costs several bus slots.

The memory address register drives the external address lines. The memory buffer register supplies the external write data and can capture the external read data. A built-in self-test sequencer runs the add-memory-to-accumulator operation in five fixed slots. While it runs, the external strobes are ignored. When more than one register drives the bus in a cycle, the bus value is not meaningful and an error flag is raised.

Top module: `sbd_core`

## Requirements
- R1: After reset the accumulator, memory address, bus value, conflict flag, write enable and self-test busy flag all read zero.
- R2: The drive-enable bits are PC=bit0, MBR=bit1, IR address field=bit2, AC=bit3, Z=bit4. The load-enable bits are PC=bit0, MAR=bit1, MBR=bit2, IR=bit3, AC=bit4, Y=bit5, Z=bit6. With one drive bit set, the bus carries that register's value, and a register whose load bit is set captures it at the clock edge. With no drive bit set, the bus reads zero.
- R3: If two or more drive bits are set in a cycle, the conflict flag is high in the following cycle. After a cycle with at most one driver, the flag is low.
- R4: Function code 00 loads Z with Y plus the bus, modulo 2^16.
- R5: Function code 01 loads Z with the bitwise AND of Y and the bus.
- R6: Function code 10 loads Z with the bus unchanged. Code 11 loads Z with the bus plus one, wrapping to zero.
- R7: Z changes only in a cycle whose Z load bit is set. The function code has no effect in other cycles.
- R8: The external address equals MAR. The memory-read strobe loads MBR from the read data, taking priority over the MBR load bit.
- R9: The write enable follows the memory-write strobe in the same cycle, and the write data equals MBR.
- R10: Driving the IR address field places IR bits 11:0 on the bus, with bits 15:12 forced to zero.
- R11: A self-test start sampled while idle holds busy high for exactly five cycles. At the edge that ends the fifth cycle, AC becomes its old value plus the memory word at the IR address. MAR then holds that address, and no conflict is flagged.
- R12: While busy, the external strobes have no effect: no extra register loads and no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| drvEn | input | 5 | Per-register bus drive enables |
| ldEn | input | 7 | Per-register bus load enables |
| memRd | input | 1 | Capture read data into MBR |
| memWr | input | 1 | Request a memory write of MBR |
| aluFn | input | 2 | ALU function code, used when Z loads |
| selfTestGo | input | 1 | Start the five-slot add sequence |
| memRdata | input | 16 | External read data |
| memAddr | output | 12 | External address (MAR) |
| memWdata | output | 16 | External write data (MBR) |
| memWe | output | 1 | External write enable |
| memRe | output | 1 | External read strobe |
| acOut | output | 16 | Accumulator value |
| busValue | output | 16 | Internal bus value |
| busConflict | output | 1 | Multiple-driver flag, one cycle late |
| selfTestBusy | output | 1 | Self-test sequence running |

## Verification
A register that captured the wrong value stays hidden until some later slot drives it onto the bus. The bench therefore follows every load with a drive step and reads the bus value in that same cycle, so a wrong state shows up one cycle after the faulty capture. A self-test that runs one slot long or short, or stages the wrong operand, shows on the accumulator and the busy flag exactly five cycles after the start. A wrong driver count shows on the conflict flag one cycle after the offending cycle.

// File: rtl/sbd_pkg.sv
`timescale 1ns/1ps
package sbd_pkg;
  localparam int NUM_DRV = 5;
  localparam int NUM_LD  = 7;

  localparam int DRV_PC  = 0;
  localparam int DRV_MBR = 1;
  localparam int DRV_IRA = 2;
  localparam int DRV_AC  = 3;
  localparam int DRV_Z   = 4;

  localparam int LD_PC  = 0;
  localparam int LD_MAR = 1;
  localparam int LD_MBR = 2;
  localparam int LD_IR  = 3;
  localparam int LD_AC  = 4;
  localparam int LD_Y   = 5;
  localparam int LD_Z   = 6;

  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_AND  = 2'b01,
    FN_PASS = 2'b10,
    FN_INC  = 2'b11
  } aluFn_e;

  typedef struct packed {
    logic [NUM_DRV-1:0] drive;
    logic [NUM_LD-1:0]  load;
    logic               memRd;
    logic               memWr;
    aluFn_e             fn;
  } ctl_t;
endpackage

// File: rtl/sbd_alu.sv
`timescale 1ns/1ps
module sbd_alu
  import sbd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] opY,
  input  logic [DW-1:0] opBus,
  input  aluFn_e        fn,
  output logic [DW-1:0] result
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    unique case (fn)
      FN_ADD:  result = opY + opBus;
      FN_AND:  result = opY & opBus;
      FN_PASS: result = opBus;
      FN_INC:  result = opBus + ONE;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/sbd_datapath.sv
`timescale 1ns/1ps
module sbd_datapath
  import sbd_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic          memRe,
  output logic [DW-1:0] acOut,
  output logic [DW-1:0] busValue,
  output logic          busConflict
);
  localparam int PAD = DW - AW;
  localparam int CW  = $clog2(NUM_DRV + 1);

  logic [AW-1:0] pcReg, marReg;
  logic [DW-1:0] mbrReg, irReg, acReg, yReg, zReg;
  logic [DW-1:0] aluResult;
  logic [DW-1:0] srcVal [NUM_DRV];
  logic [DW-1:0] gated  [NUM_DRV];
  logic [CW-1:0] driverCount;
  logic          conflictQ;

  // Bus sources, widened to the data width
  assign srcVal[DRV_PC]  = {{PAD{1'b0}}, pcReg};
  assign srcVal[DRV_MBR] = mbrReg;
  assign srcVal[DRV_IRA] = {{PAD{1'b0}}, irReg[AW-1:0]};
  assign srcVal[DRV_AC]  = acReg;
  assign srcVal[DRV_Z]   = zReg;

  // One gated lane per source; the bus is the OR of all lanes
  for (genvar i = 0; i < NUM_DRV; i++) begin : g_lane
    assign gated[i] = ctl.drive[i] ? srcVal[i] : '0;
  end

  always_comb begin
    busValue    = '0;
    driverCount = '0;
    for (int i = 0; i < NUM_DRV; i++) begin
      busValue    = busValue | gated[i];
      driverCount = driverCount + CW'(ctl.drive[i]);
    end
  end

  sbd_alu #(.DW(DW)) u_alu (
    .opY   (yReg),
    .opBus (busValue),
    .fn    (ctl.fn),
    .result(aluResult)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg     <= '0;
      marReg    <= '0;
      mbrReg    <= '0;
      irReg     <= '0;
      acReg     <= '0;
      yReg      <= '0;
      zReg      <= '0;
      conflictQ <= 1'b0;
    end else begin
      conflictQ <= (driverCount > CW'(1));
      if (ctl.load[LD_PC])  pcReg  <= busValue[AW-1:0];
      if (ctl.load[LD_MAR]) marReg <= busValue[AW-1:0];
      if (ctl.memRd)             mbrReg <= memRdata;
      else if (ctl.load[LD_MBR]) mbrReg <= busValue;
      if (ctl.load[LD_IR])  irReg  <= busValue;
      if (ctl.load[LD_AC])  acReg  <= busValue;
      if (ctl.load[LD_Y])   yReg   <= busValue;
      if (ctl.load[LD_Z])   zReg   <= aluResult;
    end
  end

  assign memAddr     = marReg;
  assign memWdata    = mbrReg;
  assign memWe       = ctl.memWr;
  assign memRe       = ctl.memRd;
  assign acOut       = acReg;
  assign busConflict = conflictQ;
endmodule

// File: rtl/sbd_selftest.sv
`timescale 1ns/1ps
module sbd_selftest
  import sbd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic go,
  output ctl_t seqCtl,
  output logic busy
);
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_T4   = 3'd4,
    S_T5   = 3'd5
  } slot_e;

  slot_e slot, slotNext;

  always_comb begin
    unique case (slot)
      S_IDLE:  slotNext = go ? S_T1 : S_IDLE;
      S_T1:    slotNext = S_T2;
      S_T2:    slotNext = S_T3;
      S_T3:    slotNext = S_T4;
      S_T4:    slotNext = S_T5;
      default: slotNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) slot <= S_IDLE;
    else       slot <= slotNext;
  end

  always_comb begin
    seqCtl = '0;
    seqCtl.fn = FN_ADD;
    unique case (slot)
      S_T1: begin
        seqCtl.drive[DRV_IRA] = 1'b1;
        seqCtl.load[LD_MAR]   = 1'b1;
      end
      S_T2: seqCtl.memRd = 1'b1;
      S_T3: begin
        seqCtl.drive[DRV_MBR] = 1'b1;
        seqCtl.load[LD_Y]     = 1'b1;
      end
      S_T4: begin
        seqCtl.drive[DRV_AC] = 1'b1;
        seqCtl.load[LD_Z]    = 1'b1;
      end
      S_T5: begin
        seqCtl.drive[DRV_Z] = 1'b1;
        seqCtl.load[LD_AC]  = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (slot != S_IDLE);
endmodule

// File: rtl/sbd_core.sv
`timescale 1ns/1ps
module sbd_core
  import sbd_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DRV-1:0] drvEn,
  input  logic [NUM_LD-1:0]  ldEn,
  input  logic               memRd,
  input  logic               memWr,
  input  logic [1:0]         aluFn,
  input  logic               selfTestGo,
  input  logic [DW-1:0]      memRdata,
  output logic [AW-1:0]      memAddr,
  output logic [DW-1:0]      memWdata,
  output logic               memWe,
  output logic               memRe,
  output logic [DW-1:0]      acOut,
  output logic [DW-1:0]      busValue,
  output logic               busConflict,
  output logic               selfTestBusy
);
  ctl_t extCtl, seqCtl, effCtl;
  logic [NUM_DRV-1:0] effDrive;
  logic [NUM_LD-1:0]  effLoad;

  always_comb begin
    extCtl.drive = drvEn;
    extCtl.load  = ldEn;
    extCtl.memRd = memRd;
    extCtl.memWr = memWr;
    extCtl.fn    = aluFn_e'(aluFn);
  end

  sbd_selftest u_seq (
    .clk   (clk),
    .rstN  (rstN),
    .go    (selfTestGo),
    .seqCtl(seqCtl),
    .busy  (selfTestBusy)
  );

  assign effCtl   = selfTestBusy ? seqCtl : extCtl;
  assign effDrive = effCtl.drive;
  assign effLoad  = effCtl.load;

  sbd_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (effCtl),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memWe      (memWe),
    .memRe      (memRe),
    .acOut      (acOut),
    .busValue   (busValue),
    .busConflict(busConflict)
  );
endmodule

// File: rtl/sbd_core_chk.sv
`timescale 1ns/1ps
module sbd_core_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic [4:0]    effDrive,
  input logic [6:0]    effLoad,
  input logic          busConflict,
  input logic          selfTestBusy,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] acOut,
  input logic [DW-1:0] busValue
);
  p_conflict_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(effDrive) > 1) |=> busConflict);

  p_conflict_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(effDrive) <= 1) |=> !busConflict);

  p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rstN)
    (effDrive == '0) |-> (busValue == '0));

  p_mar_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(effLoad[1]) |-> $stable(memAddr));

  p_busy_len_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfTestBusy) |-> selfTestBusy ##1 selfTestBusy ##1 selfTestBusy
                            ##1 selfTestBusy ##1 selfTestBusy ##1 !selfTestBusy);

  p_sum_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selfTestBusy) |-> (acOut == DW'($past(acOut) + $past(busValue, 3))));

  p_z_to_ac_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selfTestBusy) |-> (acOut == $past(busValue)));

  p_no_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    selfTestBusy |-> !memWe);
endmodule

bind sbd_core sbd_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .effDrive    (effDrive),
  .effLoad     (effLoad),
  .busConflict (busConflict),
  .selfTestBusy(selfTestBusy),
  .memWe       (memWe),
  .memAddr     (memAddr),
  .acOut       (acOut),
  .busValue    (busValue)
);

// File: tb/sbd_core_tb.sv
`timescale 1ns/1ps
module sbd_core_tb;
  localparam logic [4:0] D_PC = 5'b00001, D_MBR = 5'b00010, D_IRA = 5'b00100,
                         D_AC = 5'b01000, D_Z = 5'b10000;
  localparam logic [6:0] L_PC = 7'b0000001, L_MAR = 7'b0000010, L_IR = 7'b0001000,
                         L_AC = 7'b0010000, L_Y = 7'b0100000, L_Z = 7'b1000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] drvEn = '0;
  logic [6:0] ldEn = '0;
  logic memRd = 1'b0, memWr = 1'b0, selfTestGo = 1'b0;
  logic [1:0] aluFn = '0;
  logic [15:0] memRdata;
  logic [11:0] memAddr;
  logic [15:0] memWdata, acOut, busValue;
  logic memWe, memRe, busConflict, selfTestBusy;

  logic [15:0] mem [256];
  assign memRdata = mem[memAddr[7:0]];

  int nChecks = 0;
  int nErrs = 0;
  bit done = 0;
  logic [15:0] lastBus, lastWdata;
  logic [11:0] lastAddr;
  logic lastWe;

  always #4 clk = ~clk;

  sbd_core u_dut (
    .clk(clk), .rstN(rstN), .drvEn(drvEn), .ldEn(ldEn), .memRd(memRd),
    .memWr(memWr), .aluFn(aluFn), .selfTestGo(selfTestGo), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .acOut(acOut), .busValue(busValue), .busConflict(busConflict),
    .selfTestBusy(selfTestBusy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] d, input logic [6:0] l, input logic rd,
                      input logic wr, input logic [1:0] fn, input logic go);
    @(negedge clk);
    drvEn = d; ldEn = l; memRd = rd; memWr = wr; aluFn = fn; selfTestGo = go;
    #1;
    lastBus = busValue; lastWe = memWe; lastWdata = memWdata; lastAddr = memAddr;
    @(posedge clk);
    #1;
    drvEn = '0; ldEn = '0; memRd = 0; memWr = 0; aluFn = '0; selfTestGo = 0;
  endtask

  task automatic readWord(input logic [15:0] val);
    @(negedge clk);
    mem[memAddr[7:0]] = val;
    step(5'b0, 7'b0, 1'b1, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic tResetState();
    check("R1 acOut", acOut, 0);
    check("R1 memAddr", memAddr, 0);
    check("R1 busValue", busValue, 0);
    check("R1 busConflict", busConflict, 0);
    check("R1 memWe", memWe, 0);
    check("R1 busy", selfTestBusy, 0);
  endtask

  task automatic tBusDrive();
    readWord(16'hF020);
    step(D_MBR, L_IR, 0, 0, 0, 0);
    step(D_IRA, 0, 0, 0, 0, 0);
    check("R10 IR address on bus", lastBus, 16'h0020);
    step(D_MBR, L_AC, 0, 0, 0, 0);
    check("R2 AC load", acOut, 16'hF020);
    step(D_AC, 0, 0, 0, 0, 0);
    check("R2 AC drive", lastBus, 16'hF020);
    step(0, 0, 0, 0, 0, 0);
    check("R2 idle bus", lastBus, 0);
    step(D_IRA, L_PC, 0, 0, 0, 0);
    step(D_PC, 0, 0, 0, 0, 0);
    check("R2 PC drive", lastBus, 16'h0020);
  endtask

  task automatic tConflict();
    check("R3 flag low before", busConflict, 0);
    step(D_AC | D_MBR, 0, 0, 0, 0, 0);
    check("R3 two drivers", busConflict, 1);
    step(D_AC, 0, 0, 0, 0, 0);
    check("R3 cleared", busConflict, 0);
    step(D_PC | D_Z | D_IRA, 0, 0, 0, 0, 0);
    check("R3 three drivers", busConflict, 1);
    step(0, 0, 0, 0, 0, 0);
    check("R3 cleared idle", busConflict, 0);
  endtask

  task automatic tAlu();
    readWord(16'h1234);
    step(D_MBR, L_Y, 0, 0, 0, 0);
    readWord(16'h0F0F);
    step(D_MBR, L_Z, 0, 0, 2'b00, 0);
    step(D_Z, 0, 0, 0, 0, 0);
    check("R4 add", lastBus, 16'h2143);
    step(D_MBR, L_Z, 0, 0, 2'b01, 0);
    step(D_Z, 0, 0, 0, 0, 0);
    check("R5 and", lastBus, 16'h0204);
    step(D_MBR, 0, 0, 0, 2'b10, 0);
    step(D_Z, 0, 0, 0, 2'b11, 0);
    check("R7 fn without Z load", lastBus, 16'h0204);
    step(D_MBR, L_Z, 0, 0, 2'b10, 0);
    step(D_Z, 0, 0, 0, 0, 0);
    check("R6 pass", lastBus, 16'h0F0F);
    step(D_MBR, L_Z, 0, 0, 2'b11, 0);
    step(D_Z, 0, 0, 0, 0, 0);
    check("R6 increment", lastBus, 16'h0F10);
    readWord(16'hFFFF);
    step(D_MBR, L_Z, 0, 0, 2'b11, 0);
    step(D_Z, 0, 0, 0, 0, 0);
    check("R6 increment wrap", lastBus, 16'h0000);
    step(D_MBR, L_Y, 0, 0, 0, 0);
    readWord(16'h0003);
    step(D_MBR, L_Z, 0, 0, 2'b00, 0);
    step(D_Z, 0, 0, 0, 0, 0);
    check("R4 add wrap", lastBus, 16'h0002);
  endtask

  task automatic tMemory();
    step(D_IRA, L_MAR, 0, 0, 0, 0);
    check("R8 address is MAR", memAddr, 12'h020);
    mem[8'h20] = 16'hBEEF;
    step(D_AC, 7'b0000100, 1, 0, 0, 0);
    step(D_MBR, 0, 0, 0, 0, 0);
    check("R8 read beats bus load", lastBus, 16'hBEEF);
    step(0, 0, 0, 1, 0, 0);
    check("R9 write enable", lastWe, 1);
    check("R9 write data", lastWdata, 16'hBEEF);
    check("R9 write address", lastAddr, 12'h020);
    step(0, 0, 0, 0, 0, 0);
    check("R9 no write", lastWe, 0);
  endtask

  task automatic tSelfTest(input logic [15:0] a, input logic [15:0] b,
                           input logic [11:0] addr, input bit junk);
    readWord(a);
    step(D_MBR, L_AC, 0, 0, 0, 0);
    readWord({4'hA, addr});
    step(D_MBR, L_IR, 0, 0, 0, 0);
    @(negedge clk);
    mem[addr[7:0]] = b;
    step(0, 0, 0, 0, 0, 1);
    check("R11 busy after start", selfTestBusy, 1);
    for (int k = 1; k <= 5; k++) begin
      if (junk) begin
        step(D_PC | D_AC | D_Z, L_AC | L_MAR | L_Y, 1, 1, 2'b01, 1);
        check("R12 no write while busy", lastWe, 0);
      end else begin
        step(0, 0, 0, 0, 0, 0);
      end
      check("R11 no conflict", busConflict, 0);
      if (k < 5) begin
        check("R11 busy held", selfTestBusy, 1);
        check("R11 AC unchanged early", acOut, a);
      end
    end
    check("R11 busy ends", selfTestBusy, 0);
    check(junk ? "R12 sum despite strobes" : "R11 sum", acOut, 16'(a + b));
    check("R11 MAR at operand", memAddr, addr);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    tResetState();
    @(negedge clk);
    rstN = 1'b1;
    tBusDrive();
    tConflict();
    tAlu();
    tMemory();
    tSelfTest(16'h0100, 16'h0023, 12'h020, 1'b0);
    tSelfTest(16'hFFF0, 16'h0025, 12'h0FF, 1'b1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      nChecks++;
      nErrs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end
endmodule